// File: doc/BRIEF.md
# Sliced Integer ALU with Selectable Result Paths

This block is the integer arithmetic unit of a small datapath. It takes a left operand, a right operand, a 3-bit operation code and a 3-bit path-select code. The 16-bit core is built from four 4-bit slices joined by a lookahead carry network. The top slice also reports signed overflow. The core result reaches the shared result bus through exactly one of three alternative drivers. The first passes the whole word through. The second passes the low byte and fills the high byte with copies of its bit 7. The third shifts the word one place toward the least significant end.

The bus value and the four status flags (carry, overflow, zero, sign) are registered. They appear one clock after the inputs are sampled. A left shift has no dedicated logic: the add operation is issued with both operands equal. A rotate is built in microcode from a bit test, a shift and an OR.

Top module: `alu_zpath`

## Requirements
- R1: While `rst` is high at a rising clock edge, `zbus` and all four flags are cleared to 0 on that edge, whatever the other inputs are.
- R2: `fn` selects the operation: 0 gives zero, 1 gives opb minus opa, 2 gives opa minus opb, 3 gives opa plus opb, 4 gives XOR, 5 gives OR, 6 gives AND and 7 gives all ones. The operands and both select codes are sampled on a rising edge, and the result is visible after that same edge.
- R3: For codes 3, 1 and 2, `flag_c` is the carry out of the 16-bit sum. A subtraction is formed as minuend + ~subtrahend + 1, so `flag_c`=1 means no borrow occurred.
- R4: For codes 1, 2 and 3, `flag_v` reports two's-complement overflow of the 16-bit operation. For codes 0 and 4 to 7, `flag_v` is 0.
- R5: Code 3 with opa equal to opb yields opa shifted left by one, with `flag_c` equal to opa[15].
- R6: `zsel`=3'b001 (word path) puts all 16 result bits on `zbus` unchanged. In this path `flag_z` is set when `zbus` is 0 and `flag_n` equals `zbus[15]`.
- R7: `zsel`=3'b010 (byte path) drives result[7:0] on `zbus[7:0]` and result[7] on every bit of `zbus[15:8]`. `flag_z` is set when result[7:0] is 0 and `flag_n` equals result[7].
- R8: `zsel`=3'b100 (shift path) drives {0, result[15:1]}. `flag_c` equals result[0], and `flag_v` and `flag_n` are 0. `flag_z` is set when the shifted value is 0.
- R9: Any other `zsel` value drives `zbus`=0 with `flag_z`=1 and the other three flags 0.
- R10: For codes 0 and 4 to 7, `flag_c` is 0 in the word and byte paths.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| opa | input | 16 | Left operand |
| opb | input | 16 | Right operand |
| fn | input | 3 | Operation code |
| zsel | input | 3 | One-hot result path select |
| zbus | output | 16 | Registered result bus value |
| flag_c | output | 1 | Carry flag (or bit shifted out in the shift path) |
| flag_v | output | 1 | Signed overflow flag |
| flag_z | output | 1 | Zero flag of the driven value |
| flag_n | output | 1 | Sign flag of the driven value |

## Verification
The assertions check, on every cycle, rules that hold for any operand values. In the byte path the high byte must copy bit 7. The shift path must leave bit 15, the sign and the overflow clear. An illegal path code must produce a zero bus, and logic operations must never report carry or overflow. Whether the arithmetic itself is right can only be shown by the bench's scenarios. These compare every path and every operation against an independent model. They cover the carry and overflow boundaries (0x7FFF+1, 0xFFFF+1, 0x8000-1) and a left shift done by self-addition.

// File: rtl/alu_zpath_pkg.sv
package alu_zpath_pkg;

  localparam int unsigned FN_W   = 3;
  localparam int unsigned ZSEL_W = 3;

  typedef enum logic [FN_W-1:0] {
    OP_ZERO = 3'd0,
    OP_BSUB = 3'd1,
    OP_ASUB = 3'd2,
    OP_ADD  = 3'd3,
    OP_XOR  = 3'd4,
    OP_OR   = 3'd5,
    OP_AND  = 3'd6,
    OP_ONES = 3'd7
  } alu_op_e;

  localparam logic [ZSEL_W-1:0] PATH_WORD = 3'b001;
  localparam logic [ZSEL_W-1:0] PATH_BYTE = 3'b010;
  localparam logic [ZSEL_W-1:0] PATH_SHR  = 3'b100;

  function automatic logic op_is_arith(input logic [FN_W-1:0] f);
    return (f == OP_BSUB) || (f == OP_ASUB) || (f == OP_ADD);
  endfunction

  function automatic logic op_is_sub(input logic [FN_W-1:0] f);
    return (f == OP_BSUB) || (f == OP_ASUB);
  endfunction

endpackage

// File: rtl/alu_slice.sv
module alu_slice
  import alu_zpath_pkg::*;
#(
  parameter int unsigned SW  = 4,
  parameter bit          TOP = 1'b0
) (
  input  logic [SW-1:0]   a,
  input  logic [SW-1:0]   b,
  input  logic [FN_W-1:0] fn,
  input  logic            cin,
  output logic [SW-1:0]   f,
  output logic            grp_p,
  output logic            grp_g,
  output logic            ovf
);

  logic [SW-1:0] xop, yop, pb, gb, sum, lres;
  logic [SW:0]   ch;
  logic [SW:0]   gch;

  // operand conditioning: subtraction inverts the subtrahend
  always_comb begin
    case (fn)
      OP_BSUB: begin xop = b; yop = ~a; end
      OP_ASUB: begin xop = a; yop = ~b; end
      default: begin xop = a; yop = b;  end
    endcase
  end

  assign pb = xop ^ yop;
  assign gb = xop & yop;

  // carry chain inside the slice, fed by the lookahead carry
  always_comb begin
    ch[0]  = cin;
    gch[0] = 1'b0;
    for (int i = 0; i < SW; i++) begin
      ch[i+1]  = gb[i] | (pb[i] & ch[i]);
      gch[i+1] = gb[i] | (pb[i] & gch[i]);
    end
  end

  assign sum   = pb ^ ch[SW-1:0];
  assign grp_p = &pb;
  assign grp_g = gch[SW];

  always_comb begin
    case (fn)
      OP_ZERO: lres = '0;
      OP_XOR:  lres = a ^ b;
      OP_OR:   lres = a | b;
      OP_AND:  lres = a & b;
      OP_ONES: lres = '1;
      default: lres = '0;
    endcase
  end

  assign f = op_is_arith(fn) ? sum : lres;

  generate
    if (TOP) begin : g_ovf
      assign ovf = op_is_arith(fn) & (ch[SW] ^ ch[SW-1]);
    end else begin : g_noovf
      assign ovf = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/alu_lookahead.sv
module alu_lookahead #(
  parameter int unsigned N = 4
) (
  input  logic [N-1:0] p,
  input  logic [N-1:0] g,
  input  logic         cin,
  output logic [N:0]   c
);

  // each carry is a flat sum of products, no ripple between slices
  always_comb begin
    c[0] = cin;
    for (int i = 1; i <= N; i++) begin
      logic acc;
      logic term;
      acc = 1'b0;
      for (int j = 0; j < i; j++) begin
        term = g[j];
        for (int k = j + 1; k < i; k++) term = term & p[k];
        acc = acc | term;
      end
      term = cin;
      for (int k = 0; k < i; k++) term = term & p[k];
      c[i] = acc | term;
    end
  end

endmodule

// File: rtl/alu_zdrive.sv
module alu_zdrive
  import alu_zpath_pkg::*;
#(
  parameter int unsigned W  = 16,
  parameter int unsigned BW = 8
) (
  input  logic [W-1:0]      res,
  input  logic              cout,
  input  logic              ovf_in,
  input  logic              arith,
  input  logic [ZSEL_W-1:0] sel,
  output logic [W-1:0]      zval,
  output logic              c_o,
  output logic              v_o,
  output logic              z_o,
  output logic              n_o
);

  localparam int unsigned NPATH = 3;

  logic [W-1:0] pval [NPATH];
  logic [W-1:0] part [NPATH];
  logic         legal;

  assign pval[0] = res;
  assign pval[1] = {{(W-BW){res[BW-1]}}, res[BW-1:0]};
  assign pval[2] = {1'b0, res[W-1:1]};

  assign legal = (sel == PATH_WORD) || (sel == PATH_BYTE) || (sel == PATH_SHR);

  // one-hot AND-OR bus: at most one driver contributes
  generate
    for (genvar i = 0; i < NPATH; i++) begin : g_path
      assign part[i] = (legal && sel[i]) ? pval[i] : '0;
    end
  endgenerate

  assign zval = part[0] | part[1] | part[2];

  always_comb begin
    c_o = 1'b0;
    v_o = 1'b0;
    z_o = 1'b1;
    n_o = 1'b0;
    case (sel)
      PATH_WORD: begin
        c_o = arith & cout;
        v_o = ovf_in;
        z_o = (res == '0);
        n_o = res[W-1];
      end
      PATH_BYTE: begin
        c_o = arith & cout;
        v_o = ovf_in;
        z_o = (res[BW-1:0] == '0);
        n_o = res[BW-1];
      end
      PATH_SHR: begin
        c_o = res[0];
        z_o = (res[W-1:1] == '0);
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/alu_zpath.sv
module alu_zpath
  import alu_zpath_pkg::*;
#(
  parameter int unsigned WIDTH   = 16,
  parameter int unsigned SLICE_W = 4,
  parameter int unsigned BYTE_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WIDTH-1:0]  opa,
  input  logic [WIDTH-1:0]  opb,
  input  logic [FN_W-1:0]   fn,
  input  logic [ZSEL_W-1:0] zsel,
  output logic [WIDTH-1:0]  zbus,
  output logic              flag_c,
  output logic              flag_v,
  output logic              flag_z,
  output logic              flag_n
);

  localparam int unsigned NSLICE = WIDTH / SLICE_W;

  logic [NSLICE-1:0] sp, sg, sovf;
  logic [NSLICE:0]   carry;
  logic [WIDTH-1:0]  res;
  logic [WIDTH-1:0]  zval;
  logic              c_d, v_d, z_d, n_d;

  // R2 R3 R4: sliced core
  generate
    for (genvar s = 0; s < NSLICE; s++) begin : g_slice
      alu_slice #(
        .SW (SLICE_W),
        .TOP(s == NSLICE - 1)
      ) i_slice (
        .a    (opa[s*SLICE_W +: SLICE_W]),
        .b    (opb[s*SLICE_W +: SLICE_W]),
        .fn   (fn),
        .cin  (carry[s]),
        .f    (res[s*SLICE_W +: SLICE_W]),
        .grp_p(sp[s]),
        .grp_g(sg[s]),
        .ovf  (sovf[s])
      );
    end
  endgenerate

  alu_lookahead #(.N(NSLICE)) i_cla (
    .p  (sp),
    .g  (sg),
    .cin(op_is_sub(fn)),
    .c  (carry)
  );

  alu_zdrive #(.W(WIDTH), .BW(BYTE_W)) i_zdrv (
    .res   (res),
    .cout  (carry[NSLICE]),
    .ovf_in(|sovf),
    .arith (op_is_arith(fn)),
    .sel   (zsel),
    .zval  (zval),
    .c_o   (c_d),
    .v_o   (v_d),
    .z_o   (z_d),
    .n_o   (n_d)
  );

  // R1: registered bus and flags
  always_ff @(posedge clk) begin
    if (rst) begin
      zbus   <= '0;
      flag_c <= 1'b0;
      flag_v <= 1'b0;
      flag_z <= 1'b0;
      flag_n <= 1'b0;
    end else begin
      zbus   <= zval;
      flag_c <= c_d;
      flag_v <= v_d;
      flag_z <= z_d;
      flag_n <= n_d;
    end
  end

  // R7
  sext_fill_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(zsel) == PATH_BYTE) |->
      (zbus[WIDTH-1:BYTE_W] == {(WIDTH-BYTE_W){zbus[BYTE_W-1]}} && flag_n == zbus[BYTE_W-1]));

  // R8
  shr_msb_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(zsel) == PATH_SHR) |->
      (!zbus[WIDTH-1] && !flag_n && !flag_v));

  // R9
  illegal_sel_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && !$onehot($past(zsel))) |->
      (zbus == '0 && flag_z && !flag_c && !flag_v && !flag_n));

  // R10
  logic_noflag_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && !op_is_arith($past(fn)) && $past(zsel) != PATH_SHR) |->
      (!flag_c && !flag_v));

  // R6
  word_sign_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(zsel) == PATH_WORD) |->
      (flag_n == zbus[WIDTH-1] && flag_z == (zbus == '0)));

endmodule

// File: tb/test_alu_zpath.sv
module test_alu_zpath;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] opa = 16'hA5A5;
  logic [15:0] opb = 16'h5A5A;
  logic [2:0]  fn = 3'd3;
  logic [2:0]  zsel = 3'b001;
  logic [15:0] zbus;
  logic        flag_c, flag_v, flag_z, flag_n;

  int n_run = 0;
  int n_fail = 0;

  logic [19:0] exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;

  alu_zpath i_alu_zpath (
    .clk(clk), .rst(rst), .opa(opa), .opb(opb), .fn(fn), .zsel(zsel),
    .zbus(zbus), .flag_c(flag_c), .flag_v(flag_v), .flag_z(flag_z), .flag_n(flag_n)
  );

  // independent model: {zbus, c, v, z, n}
  function automatic logic [19:0] model(input logic [15:0] a, input logic [15:0] b,
                                        input logic [2:0] f, input logic [2:0] s);
    logic [16:0] w;
    logic [15:0] r, z;
    logic c, v, zf, nf;
    c = 1'b0; v = 1'b0; w = '0;
    case (f)
      3'd0: r = 16'h0000;
      3'd1: begin w = {1'b0, b} + {1'b0, ~a} + 17'd1; r = w[15:0]; c = w[16];
                  v = (b[15] != a[15]) && (r[15] != b[15]); end
      3'd2: begin w = {1'b0, a} + {1'b0, ~b} + 17'd1; r = w[15:0]; c = w[16];
                  v = (a[15] != b[15]) && (r[15] != a[15]); end
      3'd3: begin w = {1'b0, a} + {1'b0, b}; r = w[15:0]; c = w[16];
                  v = (a[15] == b[15]) && (r[15] != a[15]); end
      3'd4: r = a ^ b;
      3'd5: r = a | b;
      3'd6: r = a & b;
      default: r = 16'hFFFF;
    endcase
    case (s)
      3'b001: begin z = r; zf = (r == 0); nf = r[15]; end
      3'b010: begin z = {{8{r[7]}}, r[7:0]}; zf = (r[7:0] == 0); nf = r[7]; end
      3'b100: begin z = {1'b0, r[15:1]}; c = r[0]; v = 1'b0; zf = (z == 0); nf = 1'b0; end
      default: begin z = 16'h0; c = 1'b0; v = 1'b0; zf = 1'b1; nf = 1'b0; end
    endcase
    return {z, c, v, zf, nf};
  endfunction

  task automatic send(input logic [15:0] a, input logic [15:0] b,
                      input logic [2:0] f, input logic [2:0] s, input string tag);
    @(negedge clk);
    opa = a; opb = b; fn = f; zsel = s;
    exp_q.push_back(model(a, b, f, s));
    tag_q.push_back(tag);
  endtask

  // monitor: compares one result per edge, away from the edge
  always @(posedge clk) begin
    #5;
    if (exp_q.size() > 0) begin
      logic [19:0] e;
      logic [19:0] act;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      act = {zbus, flag_c, flag_v, flag_z, flag_n};
      n_run++;
      if (act !== e) begin
        n_fail++;
        $display("FAIL %s: got z=%h cvzn=%b expected z=%h cvzn=%b",
                 t, act[19:4], act[3:0], e[19:4], e[3:0]);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] pa [4];
    logic [15:0] pb [4];
    logic [2:0]  sels [6];
    pa[0] = 16'h1234; pb[0] = 16'h0F0F;
    pa[1] = 16'h8001; pb[1] = 16'h7FFF;
    pa[2] = 16'h00FF; pb[2] = 16'h00FF;
    pa[3] = 16'hF080; pb[3] = 16'h0103;
    sels[0] = 3'b001; sels[1] = 3'b010; sels[2] = 3'b100;
    sels[3] = 3'b000; sels[4] = 3'b011; sels[5] = 3'b111;

    // R1: reset clears outputs despite active inputs
    repeat (3) @(posedge clk);
    @(negedge clk);
    n_run++;
    if ({zbus, flag_c, flag_v, flag_z, flag_n} !== 20'h0) begin
      n_fail++;
      $display("FAIL R1: got z=%h cvzn=%b expected z=0000 cvzn=0000",
               zbus, {flag_c, flag_v, flag_z, flag_n});
    end
    rst = 1'b0;

    // R2 R6 R7 R8 R9 R10: every op through every path code
    for (int p = 0; p < 4; p++)
      for (int f = 0; f < 8; f++)
        for (int s = 0; s < 6; s++)
          send(pa[p], pb[p], 3'(f), sels[s], "R2/R6/R7/R8/R9/R10 sweep");

    // R3 R4: carry and overflow boundaries
    send(16'h7FFF, 16'h0001, 3'd3, 3'b001, "R4 add overflow");
    send(16'hFFFF, 16'h0001, 3'd3, 3'b001, "R3 add carry to zero");
    send(16'h8000, 16'h0001, 3'd2, 3'b001, "R4 sub overflow");
    send(16'h0001, 16'h0000, 3'd1, 3'b001, "R3 sub borrow");
    send(16'h0005, 16'h0005, 3'd2, 3'b001, "R3 sub equal no borrow");
    // R5: left shift by self-addition
    send(16'hC001, 16'hC001, 3'd3, 3'b001, "R5 shift left carry");
    send(16'h4000, 16'h4000, 3'd3, 3'b001, "R5 shift left overflow");
    // R7: byte path sign fill, zero from low byte only
    send(16'h0080, 16'h0000, 3'd5, 3'b010, "R7 sign fill");
    send(16'hFF00, 16'h0000, 3'd5, 3'b010, "R7 low byte zero");
    // R8: shift path carry and zero
    send(16'h0001, 16'h0000, 3'd5, 3'b100, "R8 shift out only bit");
    send(16'hFFFF, 16'h0000, 3'd7, 3'b100, "R8 ones shifted");

    repeat (3) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule